// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block steps an 8-bit successive-approximation conversion from a free-running conversion clock. A one-cycle start request, taken while the sequencer is idle, puts the track/hold into hold. The sequencer then waits one settling clock and resolves the code one bit per clock, from the most significant bit down. On each clock it presents a trial code to an external DAC and comparator, and reads back a single comparator flag that says whether the held input is at or above that trial level.

After the last bit decision, one more clock copies the finished code into a separate result latch. On that same clock the sequencer emits a one-cycle done pulse, drops busy, returns the track/hold to track and clears its working register. The result latch keeps the previous code for the whole of a conversion, so a reader can fetch the old value while a new conversion runs. A start request that arrives while a conversion is running is ignored.

Top module: `sar_seq`

## Requirements
- R1: While reset (`rst_n` low, sampled on the clock) is applied, and afterwards until a start is accepted, `busy`=0, `hold`=0 (track), `trial`=0, `done`=0 and `result`=0.
- R2: A `start` high sampled while idle is accepted. From the next cycle `busy`=1 and `hold`=1. During that first busy cycle `trial` stays 0, so no bit decision is made.
- R3: From the second busy cycle, `trial` tries bit 7 first (0x80), then one lower bit per cycle down to bit 0. Each trial value is the bits already decided, with the bit under test set to 1 and all lower bits at 0.
- R4: A bit under test is kept when `cmp_ge`=1 (input at or above the trial level) on the clock that ends its cycle, and cleared otherwise.
- R5: One cycle after the bit-0 decision, `result` takes the decided code, `done` is 1 for exactly one cycle, and `busy`, `hold` and `trial` return to 0. The result is visible 10 clocks after the clock that accepted `start`.
- R6: The result is the natural-binary code of the input over all 256 codes, including 0x00 and 0xFF.
- R7: `result` holds the previous conversion's value unchanged while `busy`=1.
- R8: A `start` high while `busy`=1 is ignored. The conversion in progress keeps its trial sequence, its timing and its result.
- R9: A `start` high in the cycle where `done`=1 is accepted, so conversions can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle conversion request |
| cmp_ge | input | 1 | Comparator flag: held input is at or above `trial` |
| hold | output | 1 | Track/hold control, 1 = hold, 0 = track |
| trial | output | 8 | Trial code sent to the DAC and comparator |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle end-of-conversion pulse |
| result | output | 8 | Latched code of the last finished conversion |

## Verification
A wrong bit index or a wrong keep/clear decision in the working register shows on `trial` in the very next cycle, because `trial` is the working register merged with the bit under test. The bench compares `trial` on every cycle of a conversion against a model of the comparator. A sequencing fault, such as a missing settle cycle, an extra decision or a restart by a stray start, moves the `done` pulse and the fall of `busy` off the tenth clock, so it shows within that conversion. A fault in the result latch shows either as a change of `result` while busy, or as a code different from the input once `done` is seen.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_CONV   = 2'd2,
    ST_FIN    = 2'd3
  } sar_state_t;

  // One-hot mask for the bit under test at position idx.
  function automatic logic [7:0] probe_mask(input logic [2:0] idx);
    logic [7:0] m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction

  // Trial code: already decided bits with the probe bit forced high.
  function automatic logic [7:0] trial_code(input logic [7:0] decided,
                                            input logic [2:0] idx);
    return decided | probe_mask(idx);
  endfunction

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int WIDTH         = 8,
  parameter int SETTLE_CYCLES = 1,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1,
  localparam int SET_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) + 1 : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             evt_accept,
  output logic             evt_first,
  output logic             evt_decide,
  output logic             evt_finish,
  output logic             in_conv,
  output logic [IDX_W-1:0] bit_idx,
  output logic             busy
);
  sar_state_t       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [SET_W-1:0] set_q, set_d;
  logic             settle_end;

  assign settle_end = (set_q == SET_W'(SETTLE_CYCLES - 1));
  assign evt_accept = (state_q == ST_IDLE) && start;
  assign evt_first  = (state_q == ST_SETTLE) && settle_end;
  assign evt_decide = (state_q == ST_CONV);
  assign evt_finish = (state_q == ST_FIN);
  assign in_conv    = (state_q == ST_CONV);
  assign bit_idx    = idx_q;
  assign busy       = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    set_d   = set_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_SETTLE;
        set_d   = '0;
      end
      ST_SETTLE: begin
        if (settle_end) begin
          state_d = ST_CONV;
          idx_d   = IDX_W'(WIDTH - 1);
        end else begin
          set_d = set_q + 1'b1;
        end
      end
      ST_CONV: begin
        if (idx_q == '0) state_d = ST_FIN;
        else             idx_d   = idx_q - 1'b1;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      set_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      set_q   <= set_d;
    end
  end

  // R8: a start while busy does not restart the sequence
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !evt_finish) |=> busy);
  // R2: acceptance always leads into a busy cycle
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> (busy && !in_conv));
  // R3: decisions walk downward one index per clock
  a_r3_index_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_conv && bit_idx != '0) |=> (in_conv && bit_idx == $past(bit_idx) - 1'b1));
endmodule

// File: rtl/sar_seq_reg.sv
module sar_seq_reg
  import sar_seq_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_conv,
  input  logic             evt_decide,
  input  logic             evt_finish,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             cmp_ge,
  output logic [WIDTH-1:0] trial,
  output logic [WIDTH-1:0] code
);
  logic [WIDTH-1:0] sar_q;

  assign trial = in_conv ? trial_code(sar_q, bit_idx) : sar_q & {WIDTH{evt_finish}};
  assign code  = sar_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           sar_q <= '0;
    else if (evt_finish)  sar_q <= '0;
    else if (evt_decide && cmp_ge) sar_q <= trial;
  end

  // R4: a rejected probe bit leaves the register unchanged
  a_r4_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_decide && !cmp_ge) |=> $stable(sar_q));
endmodule

// File: rtl/sar_seq_latch.sv
module sar_seq_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_finish,
  input  logic [WIDTH-1:0] code,
  output logic [WIDTH-1:0] result,
  output logic             done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= evt_finish;
      if (evt_finish) result <= code;
    end
  end

  // R5: done never lasts more than one cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int WIDTH         = 8,
  parameter int SETTLE_CYCLES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmp_ge,
  output logic             hold,
  output logic [WIDTH-1:0] trial,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result
);
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic             evt_accept, evt_first, evt_decide, evt_finish, in_conv;
  logic [IDX_W-1:0] bit_idx;
  logic [WIDTH-1:0] code;

  sar_seq_ctrl #(.WIDTH(WIDTH), .SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .evt_accept(evt_accept), .evt_first(evt_first), .evt_decide(evt_decide),
    .evt_finish(evt_finish), .in_conv(in_conv), .bit_idx(bit_idx), .busy(busy)
  );

  sar_seq_reg #(.WIDTH(WIDTH)) u_reg (
    .clk(clk), .rst_n(rst_n), .in_conv(in_conv), .evt_decide(evt_decide),
    .evt_finish(evt_finish), .bit_idx(bit_idx), .cmp_ge(cmp_ge),
    .trial(trial), .code(code)
  );

  sar_seq_latch #(.WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst_n(rst_n), .evt_finish(evt_finish), .code(code),
    .result(result), .done(done)
  );

  assign hold = busy;

  // R7: result frozen while converting, except at the transfer edge
  a_r7_result_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !evt_finish) |=> $stable(result));
  // R5: busy ends only together with a done pulse and return to track
  a_r5_end_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && !hold && trial == '0));
  // R3: first trial after settle is the MSB alone
  a_r3_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    evt_first |=> (trial == {1'b1, {(WIDTH-1){1'b0}}}));
endmodule

// File: tb/sar_seq_test.sv
module sar_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       cmp_ge;
  logic       hold, busy, done;
  logic [7:0] trial, result;
  int         vin_model = 0;
  int         n_chk = 0;
  int         n_bad = 0;
  logic [7:0] last_result = 8'h00;

  always #4 clk = ~clk;

  assign cmp_ge = (vin_model >= int'(trial));

  sar_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_ge(cmp_ge),
    .hold(hold), .trial(trial), .busy(busy), .done(done), .result(result)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // glitch: cycle (0..8) at which a stray start is driven, -1 for none
  task automatic run_conv(input int vin, input int glitch, input bit chain,
                          input bit prestarted);
    logic [7:0] dec;
    logic [7:0] tr;
    vin_model = vin;
    if (!prestarted) begin
      @(negedge clk); start = 1'b1;
    end
    @(negedge clk); start = 1'b0;
    check("R2 busy", busy, 1);
    check("R2 hold", hold, 1);
    check("R2 settle trial", trial, 0);
    dec = 8'h00;
    @(negedge clk);
    for (int k = 7; k >= 0; k--) begin
      tr = dec | (8'h01 << k);
      check("R3 trial", trial, tr);
      check("R7 result held", result, last_result);
      if (glitch == 7 - k) start = 1'b1;
      if (vin >= int'(tr)) dec = tr;   // R4 keep rule
      @(negedge clk);
      start = 1'b0;
    end
    check("R8 busy at finish", busy, 1);
    check("R5 no early done", done, 0);
    if (glitch == 8) start = 1'b1;
    @(negedge clk);
    start = chain ? 1'b1 : 1'b0;
    check("R5 done", done, 1);
    check("R5 busy low", busy, 0);
    check("R5 track", hold, 0);
    check("R5 trial zero", trial, 0);
    check("R6 result", result, vin);
    last_result = result;
    if (!chain) begin
      @(negedge clk);
      check("R5 done one cycle", done, 0);
      check("R8 stays idle", busy, 0);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 hold", hold, 0);
    check("R1 trial", trial, 0);
    check("R1 done", done, 0);
    check("R1 result", result, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle busy", busy, 0);
  endtask

  task automatic t_codes;
    run_conv(8'hA5, -1, 1'b0, 1'b0);
    run_conv(8'h00, -1, 1'b0, 1'b0);   // R6 lowest code
    run_conv(8'hFF, -1, 1'b0, 1'b0);   // R6 highest code
    run_conv(8'h80, -1, 1'b0, 1'b0);
    run_conv(8'h7F, -1, 1'b0, 1'b0);
    run_conv(8'h01, -1, 1'b0, 1'b0);
  endtask

  task automatic t_ignore;
    run_conv(8'h3C, 0, 1'b0, 1'b0);    // R8 start in first decision cycle
    run_conv(8'hC3, 5, 1'b0, 1'b0);
    run_conv(8'h5A, 8, 1'b0, 1'b0);    // R8 start in final cycle
  endtask

  task automatic t_chain;
    run_conv(8'h96, -1, 1'b1, 1'b0);   // R9 start raised with done
    run_conv(8'h69, -1, 1'b0, 1'b1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_codes();
        t_ignore();
        t_chain();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule